// File: doc/BRIEF.md
# Isochronous Bus Cycle Timer with Cycle-Match Start

This block keeps the local time base of a serial-bus node. It has three fields: a 12-bit offset inside the current bus cycle, a 13-bit cycle count and a 7-bit seconds count. A node that acts as cycle master uses the block as its time source. Each time the offset rolls over, the block raises a request to send a cycle-start message, and the payload of that message is the timer value on `timer_now`. A node that is not master overwrites the timer with the data field of each cycle-start message it receives. Between such messages the timer can keep counting on its own, so that local time does not stop.

The timer advances on a qualified tick, one pulse per 24.576 MHz period, and only while the free-run enable is high. The block also holds a one-shot cycle-match trigger. Software arms it with a 13-bit cycle number. The trigger then fires a single start pulse on the first cycle-start event that carries that cycle number, which lets a receive context begin on a chosen cycle. Firing disarms the trigger.

Top module: `bus_cycle_timer`

## Requirements
- R1: While reset is asserted and right after it, `timer_now` is 0, and `cs_req`, `match_start` and `match_armed` are 0.
- R2: When `run_en` and `tick` are high at a clock edge and no load takes place, the offset field rises by one. When `run_en` or `tick` is low and no load takes place, the timer keeps its value.
- R3: A step taken with the offset at 3071 sets the offset to 0 and raises the cycle count by one.
- R4: A step that wraps the offset while the cycle count is 7999 sets the cycle count to 0 and raises the seconds count by one. A seconds count of 127 wraps to 0.
- R5: When `is_master` is low, a clock edge with `cs_rx_valid` high loads `cs_rx_data` into the timer. The load takes priority over a step. The layout is seconds in bits 31:25, cycle in bits 24:12 and offset in bits 11:0. The same layout is used on `timer_now`.
- R6: When `is_master` is high, `cs_rx_valid` and `cs_rx_data` have no effect on the timer.
- R7: `cs_req` is high for exactly the one cycle in which the offset has just wrapped to 0 by a step taken as master. It is never high for a step taken with `is_master` low.
- R8: A cycle-start event is either a load (R5) or a master offset wrap (R7). Its cycle value is the cycle count the timer takes at that edge. If the trigger is armed and that value equals the armed match cycle, `match_start` is high for the one cycle that follows that edge.
- R9: A clock edge with `match_arm` high stores `match_cycle` and sets `match_armed`. A firing start clears `match_armed` at the same edge, unless that edge also re-arms. Until it is armed again, no further start pulse occurs.
- R10: No start pulse occurs while the trigger is disarmed, or for an event whose cycle value differs from the armed one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One pulse per offset period |
| run_en | input | 1 | Free-run counting enable |
| is_master | input | 1 | Node acts as cycle master |
| cs_rx_valid | input | 1 | Received cycle-start strobe |
| cs_rx_data | input | 32 | Received cycle-start time value |
| match_arm | input | 1 | Arms the cycle-match trigger |
| match_cycle | input | 13 | Cycle number to match |
| timer_now | output | 32 | Current time {seconds, cycle, offset} |
| cs_req | output | 1 | Cycle-start send request (master) |
| match_armed | output | 1 | Match trigger is armed |
| match_start | output | 1 | Single-cycle context start pulse |

## Verification
The assertions assume that a received cycle-start value has an offset below 3072 and a cycle count below 8000. Out-of-range values are loaded as given and are not checked. The stimulus therefore draws every received field modulo its limit. It steers part of the loads close to the offset, cycle and seconds rollovers, so that random runs reach the carries quickly. The stimulus often sets the armed cycle to the cycle that comes next, so that matches happen frequently during random runs.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int OFF_W = 12;
  localparam int CYC_W = 13;
  localparam int SEC_W = 7;
  localparam int TIME_W = OFF_W + CYC_W + SEC_W;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [CYC_W-1:0] cyc;
    logic [OFF_W-1:0] off;
  } ct_time_t;
endpackage

// File: rtl/ct_time_counter.sv
module ct_time_counter
  import ct_pkg::*;
#(
  parameter int OFF_LIMIT = 3072,
  parameter int CYC_LIMIT = 8000,
  parameter int SEC_LIMIT = 128
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     step,
  input  logic     load,
  input  ct_time_t load_val,
  output ct_time_t cur,
  output ct_time_t nxt,
  output logic     off_wrap
);
  localparam logic [OFF_W-1:0] OFF_TOP = OFF_W'(OFF_LIMIT - 1);
  localparam logic [CYC_W-1:0] CYC_TOP = CYC_W'(CYC_LIMIT - 1);
  localparam logic [SEC_W-1:0] SEC_TOP = SEC_W'(SEC_LIMIT - 1);

  logic en;

  always_comb begin
    nxt = cur;
    if (load) begin
      nxt = load_val;
    end else if (step) begin
      if (cur.off >= OFF_TOP) begin
        nxt.off = '0;
        if (cur.cyc >= CYC_TOP) begin
          nxt.cyc = '0;
          nxt.sec = (cur.sec >= SEC_TOP) ? '0 : cur.sec + 1'b1;
        end else begin
          nxt.cyc = cur.cyc + 1'b1;
        end
      end else begin
        nxt.off = cur.off + 1'b1;
      end
    end
  end

  assign en       = load | step;
  assign off_wrap = step & ~load & (cur.off >= OFF_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cur <= '0;
    else if (en) cur <= nxt;
  end

  // R2: a plain step moves only the offset, by one
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && cur.off < OFF_TOP) |=>
      (cur.off == OFF_W'($past(cur.off) + 1'b1)) && $stable(cur.cyc) && $stable(cur.sec));

  // R2: no step, no load, no change
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(cur));

  // R3: offset rollover returns to zero
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && cur.off >= OFF_TOP) |=> (cur.off == '0));

  // R5: load copies the received value
  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cur == $past(load_val)));
endmodule

// File: rtl/ct_cycle_match.sv
module ct_cycle_match
  import ct_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [CYC_W-1:0] arm_cycle,
  input  logic             ev_valid,
  input  logic [CYC_W-1:0] ev_cycle,
  output logic             armed,
  output logic             start
);
  logic [CYC_W-1:0] target_q, target_d;
  logic             armed_d, start_d, hit;

  assign hit = armed & ev_valid & (ev_cycle == target_q);

  always_comb begin
    target_d = arm ? arm_cycle : target_q;
    start_d  = hit;
    if (arm)      armed_d = 1'b1;
    else if (hit) armed_d = 1'b0;
    else          armed_d = armed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_q <= '0;
      armed    <= 1'b0;
      start    <= 1'b0;
    end else begin
      if (arm) target_q <= target_d;
      armed <= armed_d;
      start <= start_d;
    end
  end

  // R8: a start pulse requires an armed trigger one cycle earlier
  p_fire_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> $past(armed));

  // R9: firing disarms unless re-armed on the same edge
  p_disarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !$past(arm)) |-> !armed);
endmodule

// File: rtl/bus_cycle_timer.sv
module bus_cycle_timer
  import ct_pkg::*;
#(
  parameter int OFF_LIMIT = 3072,
  parameter int CYC_LIMIT = 8000,
  parameter int SEC_LIMIT = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run_en,
  input  logic              is_master,
  input  logic              cs_rx_valid,
  input  logic [TIME_W-1:0] cs_rx_data,
  input  logic              match_arm,
  input  logic [CYC_W-1:0]  match_cycle,
  output logic [TIME_W-1:0] timer_now,
  output logic              cs_req,
  output logic              match_armed,
  output logic              match_start
);
  ct_time_t         cur, nxt;
  logic             load, step, off_wrap, master_wrap, ev_valid;
  logic [CYC_W-1:0] ev_cycle;

  assign load        = ~is_master & cs_rx_valid;
  assign step        = run_en & tick;
  assign master_wrap = is_master & off_wrap;
  assign ev_valid    = load | master_wrap;
  assign ev_cycle    = nxt.cyc;

  ct_time_counter #(
    .OFF_LIMIT(OFF_LIMIT),
    .CYC_LIMIT(CYC_LIMIT),
    .SEC_LIMIT(SEC_LIMIT)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .load     (load),
    .load_val (ct_time_t'(cs_rx_data)),
    .cur      (cur),
    .nxt      (nxt),
    .off_wrap (off_wrap)
  );

  ct_cycle_match u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (match_arm),
    .arm_cycle (match_cycle),
    .ev_valid  (ev_valid),
    .ev_cycle  (ev_cycle),
    .armed     (match_armed),
    .start     (match_start)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_req <= 1'b0;
    else        cs_req <= master_wrap;
  end

  assign timer_now = cur;

  // R7: the send request lasts one cycle
  p_req_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_req |=> !cs_req);

  // R7: the request coincides with a zero offset and a master step
  p_req_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_req |-> (cur.off == '0) && $past(is_master));

  // R6: as master, received data never moves the timer
  p_master_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && !(run_en && tick)) |=> $stable(timer_now));
endmodule

// File: tb/sim_bus_cycle_timer.sv
`timescale 1ns/1ps
module sim_bus_cycle_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick, run_en, is_master, cs_rx_valid, match_arm;
  logic [31:0] cs_rx_data;
  logic [12:0] match_cycle;
  logic [31:0] timer_now;
  logic        cs_req, match_armed, match_start;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] m_t;
  logic        m_req, m_start, m_armed;
  logic [12:0] m_mv;

  always #5 clk = ~clk;

  bus_cycle_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run_en(run_en), .is_master(is_master),
    .cs_rx_valid(cs_rx_valid), .cs_rx_data(cs_rx_data), .match_arm(match_arm),
    .match_cycle(match_cycle), .timer_now(timer_now), .cs_req(cs_req),
    .match_armed(match_armed), .match_start(match_start)
  );

  function automatic logic [31:0] mk(input int s, input int c, input int o);
    return {7'(s), 13'(c), 12'(o)};
  endfunction

  function automatic logic [31:0] advance(input logic [31:0] t);
    int s, c, o;
    s = int'(t[31:25]); c = int'(t[24:12]); o = int'(t[11:0]);
    o = o + 1;
    if (o == 3072) begin
      o = 0; c = c + 1;
      if (c == 8000) begin c = 0; s = (s + 1) % 128; end
    end
    return mk(s, c, o);
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic model_edge();
    logic ev;
    logic [12:0] c;
    ev = 1'b0; c = '0; m_req = 1'b0;
    if (!is_master && cs_rx_valid) begin
      m_t = cs_rx_data; ev = 1'b1; c = cs_rx_data[24:12];
    end else if (run_en && tick) begin
      if (is_master && m_t[11:0] == 12'd3071) m_req = 1'b1;
      m_t = advance(m_t);
      if (m_req) begin ev = 1'b1; c = m_t[24:12]; end
    end
    m_start = m_armed && ev && (c == m_mv);
    if (match_arm) begin m_armed = 1'b1; m_mv = match_cycle; end
    else if (m_start) m_armed = 1'b0;
  endtask

  task automatic clk_step(input string rt);
    @(posedge clk);
    model_edge();
    #1;
    chk(rt, timer_now, m_t);
    chk("R7 cs_req", {31'd0, cs_req}, {31'd0, m_req});
    chk("R8 match_start", {31'd0, match_start}, {31'd0, m_start});
    chk("R9 match_armed", {31'd0, match_armed}, {31'd0, m_armed});
  endtask

  task automatic idle_in();
    tick = 0; run_en = 0; is_master = 0; cs_rx_valid = 0; cs_rx_data = '0;
    match_arm = 0; match_cycle = '0;
  endtask

  task automatic load_val(input logic [31:0] v);
    is_master = 0; cs_rx_valid = 1; cs_rx_data = v; tick = 0;
    clk_step("R5 load");
    cs_rx_valid = 0;
  endtask

  initial begin
    #2_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired, actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'h5eed1394);
    idle_in();
    rst_n = 0;
    m_t = '0; m_req = 0; m_start = 0; m_armed = 0; m_mv = '0;
    #23;
    chk("R1 timer", timer_now, 32'd0);
    chk("R1 flags", {29'd0, cs_req, match_start, match_armed}, 32'd0);
    rst_n = 1;
    clk_step("R1 after reset");

    // R2: counting, and holds without tick or enable
    run_en = 1; tick = 1;
    for (int i = 0; i < 5; i++) clk_step("R2 step");
    chk("R2 offset five", timer_now, mk(0, 0, 5));
    tick = 0; clk_step("R2 hold no tick");
    tick = 1; run_en = 0; clk_step("R2 hold no run");
    run_en = 1;

    // R3: offset rollover
    load_val(mk(3, 17, 3070));
    tick = 1; clk_step("R3 pre");
    clk_step("R3 wrap");
    chk("R3 wrap value", timer_now, mk(3, 18, 0));

    // R4: cycle and seconds rollover
    load_val(mk(5, 7999, 3071));
    tick = 1; clk_step("R4 cycle wrap");
    chk("R4 cycle wrap value", timer_now, mk(6, 0, 0));
    load_val(mk(127, 7999, 3071));
    tick = 1; clk_step("R4 seconds wrap");
    chk("R4 seconds wrap value", timer_now, mk(0, 0, 0));

    // R5: load beats a step
    tick = 1; cs_rx_valid = 1; cs_rx_data = mk(9, 100, 200);
    clk_step("R5 load over step");
    chk("R5 loaded", timer_now, mk(9, 100, 200));
    cs_rx_valid = 0;

    // R6: master ignores received data
    is_master = 1; tick = 0; cs_rx_valid = 1; cs_rx_data = mk(1, 2, 3);
    clk_step("R6 ignore");
    chk("R6 unchanged", timer_now, mk(9, 100, 200));
    cs_rx_valid = 0;

    // R7 and R8: master wrap with armed match
    load_val(mk(2, 41, 3070));
    match_arm = 1; match_cycle = 13'd42; clk_step("R9 arm");
    match_arm = 0;
    is_master = 1; tick = 1;
    clk_step("R7 pre");
    clk_step("R7 wrap");
    chk("R7 req at wrap", {31'd0, cs_req}, 32'd1);
    chk("R8 start at wrap", {31'd0, match_start}, 32'd1);
    clk_step("R7 after");
    chk("R7 single", {31'd0, cs_req}, 32'd0);
    chk("R9 disarmed", {31'd0, match_armed}, 32'd0);

    // R10: slave wrap gives no request; mismatched cycle no start
    is_master = 0; tick = 0;
    match_arm = 1; match_cycle = 13'd500; clk_step("R10 arm");
    match_arm = 0;
    load_val(mk(0, 499, 3071));
    chk("R10 mismatch no start", {31'd0, match_start}, 32'd0);
    tick = 1; clk_step("R7 slave wrap");
    chk("R7 no slave req", {31'd0, cs_req}, 32'd0);
    tick = 0;
    load_val(mk(0, 500, 10));
    chk("R8 slave match", {31'd0, match_start}, 32'd1);
    load_val(mk(0, 500, 20));
    chk("R9 no second start", {31'd0, match_start}, 32'd0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int s, c, o;
      is_master   = ($urandom % 4) == 0;
      run_en      = ($urandom % 8) != 0;
      tick        = ($urandom % 4) != 0;
      cs_rx_valid = ($urandom % 6) == 0;
      s = $urandom % 128; c = $urandom % 8000; o = $urandom % 3072;
      if (($urandom % 3) == 0) o = 3071 - ($urandom % 3);
      if (($urandom % 5) == 0) c = 7999;
      if (($urandom % 5) == 0) s = 127;
      cs_rx_data  = mk(s, c, o);
      match_arm   = ($urandom % 10) == 0;
      match_cycle = (($urandom % 2) == 0) ? 13'((int'(m_t[24:12]) + 1) % 8000) : 13'(c);
      clk_step("R5 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule